// File: doc/BRIEF.md
# Redundant-Copy Majority Vote Decoder

This block rebuilds a table of read-retry settings from a raw parameter area that was read out of a flash device. That area is unreliable, so every field in it is stored eight times. The value table is also stored a second time, bit-inverted. Bytes are streamed into a local buffer by index. A start strobe then launches the decode. First the block votes out the mode count and the register count. Next it votes out every (mode, register) value and writes each recovered value into an external table through a write-enable, address and data port.

A vote passes only when at least six of the eight copies agree. If the plain copies of a value fail the vote, the block votes on the inverted copies and complements the winner. If either count fails, or a value fails both votes, or a copy position lies past the bytes that were loaded, the decode ends with an error.

Top module: `rr_vote_decoder`

## Requirements
- R1: While idle, a byte presented with `in_valid` is stored at `in_idx`. The loaded length is one more than the highest index stored since the previous decode ended. The loaded length is cleared when a decode ends.
- R2: The mode count is voted from bytes 0..7 and the register count from bytes 8..15, with no inverted fallback. Both are presented on `num_modes` and `num_regs` when `done` rises on success.
- R3: With S = modes × registers and v = m × registers + r, copy x of value v is read at byte 16 + (2x)·S + v in the plain set and at byte 16 + (2x+1)·S + v in the inverted set.
- R4: Only copies at positions 0..3 are candidates, taken in ascending order. A candidate wins when more than 4 of the copies after it equal it, so at least 6 of the 8 copies must agree.
- R5: When the plain copies of a value produce no winner, the inverted copies are voted, and the bitwise complement of their winner is written.
- R6: When either count fails its vote, or a value fails both votes, `done` and `err` pulse together and no further table write occurs.
- R7: A copy position at or beyond the loaded length ends the decode with `err`.
- R8: Values are written in mode-major order with `tbl_addr` = v. `done` rises in the cycle after the last write, and never in the same cycle as a write.
- R9: When the voted mode count or register count is zero, the decode completes with `done`, no `err`, and no table writes.
- R10: `done` and `err` are single-cycle pulses. A `start` pulse during a decode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for one buffer byte |
| in_idx | input | 10 | Buffer index of the loaded byte |
| in_byte | input | 8 | Loaded byte |
| start | input | 1 | Begin decode (idle only) |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | 16 | Table entry index, mode-major |
| tbl_data | output | 8 | Recovered value |
| num_modes | output | 8 | Voted mode count |
| num_regs | output | 8 | Voted register count |
| done | output | 1 | Decode finished pulse |
| err | output | 1 | Decode failed pulse (with done) |

## Verification
The hardest cases to reach are the ones near the quorum edge. In one, exactly six copies agree and the winner is the third candidate. In the other, exactly five agree, which must fall through to the inverted set. The bench corrupts chosen copy positions in an image it builds itself. It spoils the inverted copies of a value that should win on the plain set, so a wrongful fallback shows up as a wrong data byte. It also truncates the loaded image so that only a copy-position read can run off the end.

// File: rtl/rr_vote_pkg.sv
package rr_vote_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 24;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CAP,
        ST_VOTE,
        ST_DONE,
        ST_FAIL
    } dec_state_t;

    typedef enum logic [1:0] {
        PH_MODES,
        PH_REGS,
        PH_VALS
    } dec_phase_t;

    // Byte offset of one copy of the field currently being voted.
    function automatic logic [OFF_W-1:0] copy_offset(
        input dec_phase_t       ph,
        input logic [3:0]       slot,      // 2*copy + inverted
        input logic [OFF_W-1:0] set_size,
        input logic [OFF_W-1:0] val_idx,
        input logic [OFF_W-1:0] hdr_span,  // copies per field
        input logic [OFF_W-1:0] copy_idx
    );
        logic [OFF_W-1:0] o;
        case (ph)
            PH_MODES: o = copy_idx;
            PH_REGS:  o = hdr_span + copy_idx;
            default:  o = (hdr_span << 1) + OFF_W'(slot) * set_size + val_idx;
        endcase
        return o;
    endfunction
endpackage

// File: rtl/rr_copy_buf.sv
module rr_copy_buf #(
    parameter int DEPTH = 784,
    parameter int AW    = 10
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  rr_vote_pkg::byte_t          wr_data,
    input  logic [AW-1:0]               rd_addr,
    output rr_vote_pkg::byte_t          rd_data
);
    rr_vote_pkg::byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/rr_vote.sv
module rr_vote #(
    parameter int NCOPY = 8
) (
    input  logic [NCOPY-1:0][7:0] copies,
    output logic                  win,
    output rr_vote_pkg::byte_t    winner
);
    localparam int HALF = NCOPY / 2;
    localparam int CW   = $clog2(NCOPY + 1);

    logic [HALF-1:0] qual;

    generate
        for (genvar c = 0; c < HALF; c++) begin : g_cand
            logic [CW-1:0] hits;
            always_comb begin
                hits = '0;
                for (int j = c + 1; j < NCOPY; j++)
                    if (copies[j] == copies[c]) hits = hits + CW'(1);
            end
            assign qual[c] = hits > CW'(HALF);
        end
    endgenerate

    // Lowest qualifying position wins.
    always_comb begin
        win    = 1'b0;
        winner = '0;
        for (int c = HALF - 1; c >= 0; c--) begin
            if (qual[c]) begin
                win    = 1'b1;
                winner = copies[c];
            end
        end
    end

    logic [CW-1:0] agree;
    always_comb begin
        agree = '0;
        for (int j = 0; j < NCOPY; j++)
            agree = agree + CW'(copies[j] == winner);
        if (win) begin
            assert_quorum_R4: assert (agree >= CW'(HALF + 2));
        end
    end
endmodule

// File: rtl/rr_vote_decoder.sv
module rr_vote_decoder #(
    parameter int DEPTH  = 784,
    parameter int NCOPY  = 8,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int TBL_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [7:0]        in_byte,
    input  logic              start,
    output logic              tbl_we,
    output logic [TBL_AW-1:0] tbl_addr,
    output logic [7:0]        tbl_data,
    output logic [7:0]        num_modes,
    output logic [7:0]        num_regs,
    output logic              done,
    output logic              err
);
    import rr_vote_pkg::*;

    localparam int LEN_W = IDX_W + 1;
    localparam int KW    = $clog2(NCOPY);

    dec_state_t             state;
    dec_phase_t             phase;
    logic [KW-1:0]          k;
    logic                   inv;
    logic [OFF_W-1:0]       val_idx;
    logic [LEN_W-1:0]       load_len;
    logic [NCOPY-1:0][7:0]  copies;
    byte_t                  rd_data;
    logic                   win;
    byte_t                  winner;
    logic [OFF_W-1:0]       set_size;
    logic [OFF_W-1:0]       off;
    logic                   wr_en;

    assign set_size = OFF_W'(num_modes) * OFF_W'(num_regs);
    assign off = copy_offset(phase, 4'({k, inv}), set_size, val_idx,
                             OFF_W'(NCOPY), OFF_W'(k));
    assign wr_en = in_valid && (state == ST_IDLE)
                && ({1'b0, in_idx} < LEN_W'(DEPTH));

    rr_copy_buf #(.DEPTH(DEPTH), .AW(IDX_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (in_idx),
        .wr_data (in_byte),
        .rd_addr (off[IDX_W-1:0]),
        .rd_data (rd_data)
    );

    rr_vote #(.NCOPY(NCOPY)) u_vote (
        .copies (copies),
        .win    (win),
        .winner (winner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_MODES;
            k         <= '0;
            inv       <= 1'b0;
            val_idx   <= '0;
            load_len  <= '0;
            copies    <= '0;
            num_modes <= '0;
            num_regs  <= '0;
            tbl_we    <= 1'b0;
            tbl_addr  <= '0;
            tbl_data  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            tbl_we <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (wr_en && ({1'b0, in_idx} + LEN_W'(1) > load_len))
                        load_len <= {1'b0, in_idx} + LEN_W'(1);
                    if (start) begin
                        phase <= PH_MODES;
                        k     <= '0;
                        inv   <= 1'b0;
                        state <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (off >= OFF_W'(load_len)) state <= ST_FAIL;
                    else                         state <= ST_CAP;
                end
                ST_CAP: begin
                    copies[k] <= rd_data;
                    if (k == KW'(NCOPY - 1)) state <= ST_VOTE;
                    else begin
                        k     <= k + KW'(1);
                        state <= ST_ADDR;
                    end
                end
                ST_VOTE: begin
                    k <= '0;
                    if (!win) begin
                        if (phase == PH_VALS && !inv) begin
                            inv   <= 1'b1;
                            state <= ST_ADDR;
                        end else begin
                            state <= ST_FAIL;
                        end
                    end else begin
                        case (phase)
                            PH_MODES: begin
                                num_modes <= winner;
                                phase     <= PH_REGS;
                                state     <= ST_ADDR;
                            end
                            PH_REGS: begin
                                num_regs <= winner;
                                val_idx  <= '0;
                                inv      <= 1'b0;
                                phase    <= PH_VALS;
                                if (winner == '0 || num_modes == '0) state <= ST_DONE;
                                else                                 state <= ST_ADDR;
                            end
                            default: begin
                                tbl_we   <= 1'b1;
                                tbl_addr <= val_idx[TBL_AW-1:0];
                                tbl_data <= inv ? ~winner : winner;
                                inv      <= 1'b0;
                                if (val_idx == set_size - OFF_W'(1)) state <= ST_DONE;
                                else begin
                                    val_idx <= val_idx + OFF_W'(1);
                                    state   <= ST_ADDR;
                                end
                            end
                        endcase
                    end
                end
                ST_DONE: begin
                    done     <= 1'b1;
                    load_len <= '0;
                    state    <= ST_IDLE;
                end
                default: begin
                    done     <= 1'b1;
                    err      <= 1'b1;
                    load_len <= '0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    assert_no_write_after_err_R6: assert property (@(posedge clk) disable iff (rst)
        err |=> !tbl_we);
    assert_done_not_with_write_R8: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> !done);
    assert_addr_in_table_R8: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> (OFF_W'(tbl_addr) < OFF_W'(num_modes) * OFF_W'(num_regs)));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/rr_vote_decoder_tb_top.sv
module rr_vote_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 784;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [9:0]  in_idx;
    logic [7:0]  in_byte;
    logic        start;
    logic        tbl_we;
    logic [15:0] tbl_addr;
    logic [7:0]  tbl_data;
    logic [7:0]  num_modes;
    logic [7:0]  num_regs;
    logic        done;
    logic        err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rr_vote_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
        .in_byte(in_byte), .start(start), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .num_modes(num_modes),
        .num_regs(num_regs), .done(done), .err(err)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
    } wr_item_t;

    wr_item_t   exp_q[$];
    logic [7:0] img [DEPTH];
    logic [7:0] truth [64];
    int n_checks = 0;
    int n_fail   = 0;
    int done_cnt = 0;
    logic saw_err;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_write(input int a, input logic [7:0] d);
        wr_item_t it;
        it.addr = 16'(a);
        it.data = d;
        exp_q.push_back(it);
    endtask

    // Monitor: compare every table write against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && tbl_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected write", int'(tbl_addr), -1);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check(tbl_addr == e.addr, "R8 write address", int'(tbl_addr), int'(e.addr));
                check(tbl_data == e.data, "R3/R5 write data", int'(tbl_data), int'(e.data));
            end
        end
        if (!rst && done) begin
            done_cnt++;
            check(!tbl_we, "R8 done with write", 1, 0);
        end
    end

    // Builds a clean image; returns its length.
    task automatic build(input int nm, input int nr, output int len);
        int s;
        s = nm * nr;
        for (int i = 0; i < DEPTH; i++) img[i] = 8'h00;
        for (int x = 0; x < 8; x++) begin
            img[x]     = 8'(nm);
            img[8 + x] = 8'(nr);
        end
        for (int v = 0; v < s; v++) begin
            truth[v] = 8'((v * 29 + 3) ^ 8'h5A);
            for (int x = 0; x < 8; x++) begin
                img[16 + (2 * x) * s + v]     = truth[v];
                img[16 + (2 * x + 1) * s + v] = ~truth[v];
            end
        end
        len = 16 + 16 * s;
    endtask

    task automatic load(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_idx   = 10'(i);
            in_byte  = img[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done, req, 0, 1);
        saw_err = err;
    endtask

    task automatic finish_case(input string req, input logic exp_err);
        check(saw_err == exp_err, req, int'(saw_err), int'(exp_err));
        check(exp_q.size() == 0, "R8 missing writes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int len;
        int dc;
        rst = 1'b1; in_valid = 1'b0; in_idx = '0; in_byte = '0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !err && !tbl_we, "R10 reset outputs idle", int'({done, err, tbl_we}), 0);

        // Clean image; register count with copies 0,1 spoiled (R2, R4); extra start mid-run (R10).
        build(3, 4, len);
        img[8] = 8'hEE; img[9] = 8'hDD;
        for (int v = 0; v < 12; v++) expect_write(v, truth[v]);
        load(len);                                     // R1
        dc = done_cnt;
        pulse_start;
        repeat (20) @(negedge clk);
        pulse_start;                                   // R10 ignored while busy
        wait_done("R8 clean decode done");
        check(num_modes == 8'd3, "R2 mode count", int'(num_modes), 3);
        check(num_regs == 8'd4, "R2 register count", int'(num_regs), 4);
        finish_case("R2 clean no err", 1'b0);
        repeat (40) @(negedge clk);
        check(done_cnt - dc == 1, "R10 single done pulse", done_cnt - dc, 1);

        // Fallback cases (R4, R5).
        build(2, 4, len);
        for (int x = 0; x < 3; x++) img[16 + (2 * x) * 8 + 5] = truth[5] ^ 8'(x + 1);
        for (int x = 4; x < 8; x++) img[16 + (2 * x) * 8 + 2] = truth[2] ^ 8'(x * 3);
        img[16 + 0 * 8 + 7] = truth[7] ^ 8'h33;
        img[16 + 2 * 8 + 7] = truth[7] ^ 8'h44;
        for (int x = 0; x < 8; x++) img[16 + (2 * x + 1) * 8 + 7] = 8'h00;
        for (int v = 0; v < 8; v++) expect_write(v, truth[v]);
        load(len);
        pulse_start;
        wait_done("R5 fallback done");
        finish_case("R4 six-of-eight and R5 inverted retry", 1'b0);

        // Value fails both votes (R6).
        build(2, 2, len);
        for (int x = 0; x < 3; x++) begin
            img[16 + (2 * x) * 4]     = 8'(x + 1);
            img[16 + (2 * x + 1) * 4] = 8'(x + 9);
        end
        load(len);
        pulse_start;
        wait_done("R6 value failure done");
        finish_case("R6 value failure err", 1'b1);

        // Mode count with only five agreeing (R4, R6).
        build(2, 2, len);
        for (int x = 5; x < 8; x++) img[x] = 8'(x);
        load(len);
        pulse_start;
        wait_done("R6 count failure done");
        finish_case("R4 five-of-eight count err", 1'b1);

        // Truncated load (R7).
        build(2, 2, len);
        load(20);
        pulse_start;
        wait_done("R7 short load done");
        finish_case("R7 offset past length err", 1'b1);

        // Zero mode count (R9).
        build(0, 5, len);
        load(len);
        pulse_start;
        wait_done("R9 zero count done");
        check(num_modes == 8'd0, "R9 mode count zero", int'(num_modes), 0);
        finish_case("R9 zero count no err", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule